// File: doc/BRIEF.md
# Predicate-Register Transfer Unit

This execution unit moves one-bit flags between a shader core's bank of seven programmable predicates and its 32-bit general-purpose registers. It takes a 64-bit instruction word, recognises two immediate-form opcodes, and produces either a set of predicate writes or one register write. A 7-bit immediate mask chooses which predicates take part. A 2-bit lane field chooses which byte of the register is involved.

In the register-to-predicate direction, the unit reads one byte of the source register. Each predicate whose mask bit is set takes the matching bit of that byte. In the predicate-to-register direction, the unit packs the predicates under the mask into a byte. It splices that byte into the source register value and sends the whole word to the destination register. The unit sits behind a valid/ready handshake and registers its result once. The predicate bank and the register file stay outside the unit. The unit sees the current predicates and the source-register data, and it drives write enables and write data back to them. Condition-code mode and any unrecognised opcode raise an unsupported flag and cause no write.

Top module: `pred_xfer_unit`

## Requirements
- R1: The top 16 instruction bits select the register-to-predicate form when they match 0011100x11110xxx (x = either value). For each i in 0..6 with immediate mask bit i set (mask = instruction bits [26:20]), the unit writes predicate i with source-register bit (8*lane + i).
- R2: In the register-to-predicate form, a predicate whose mask bit is clear gets no write enable, so it keeps its value.
- R3: The lane is instruction bits [42:41]. It places the byte used by both forms at bit offset 8*lane, covering lanes 0 to 3.
- R4: The top 16 bits select the predicate-to-register form when they match 0011100x11101xxx. The unit then writes the register named by instruction bits [7:0]. The written value is the source register (named by bits [15:8]) with its selected byte replaced. Bit i of the new byte is (predicate i AND mask bit i), and bit 7 is 0.
- R5: A source index of 255 reads as the value zero in both forms.
- R6: A predicate-to-register operation with destination index 255 writes no register and is not flagged unsupported.
- R7: When instruction bit 40 is 1 (condition-code mode), either recognised form raises the unsupported flag and performs no write. Bit 40 equal to 0 is predicate mode.
- R8: An instruction whose top 16 bits match neither form raises the unsupported flag and performs no write.
- R9: An accepted instruction (in_valid and in_ready both high at a clock edge) shows its result with out_valid high after that edge. After reset, out_valid, the unsupported flag and all write enables are low. When out_valid is low, the unsupported flag and all write enables are low.
- R10: While out_valid is high and out_ready is low, in_ready is low and every output holds its value. Otherwise in_ready is high.
- R11: The register-to-predicate form never asserts the register write enable. The predicate-to-register form never asserts a predicate write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit can accept an instruction this cycle |
| instr | input | 64 | Instruction word |
| src_idx | output | 8 | Read index for the source register (instruction bits [15:8]) |
| src_data | input | 32 | Read data for src_idx |
| pred_in | input | 7 | Current predicate bank |
| out_ready | input | 1 | Consumer accepts the result |
| out_valid | output | 1 | Result valid |
| out_unsup | output | 1 | Instruction not supported |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 8 | Register write index |
| rf_wdata | output | 32 | Register write data |
| pred_we | output | 7 | Per-predicate write enable |
| pred_wdata | output | 7 | Predicate write data |

## Verification
The bench builds the unit with its default 32-bit data width, so the register holds exactly four byte lanes. Every lane code, including the top lane at bits 31:24, therefore lands on a real byte, and the splice can be seen at both ends of the word. With seven predicates set against an eight-bit lane, the always-zero bit 7 appears in every predicate-to-register result. Random phases vary the don't-care opcode bits, the mode bit, the index values 255 and backpressure on out_ready.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

    // Fixed instruction format
    localparam int INSTR_W    = 64;
    localparam int NUM_PRED   = 7;
    localparam int IDX_W      = 8;
    localparam int LANE_W     = 2;
    localparam int BYTE_W     = 8;

    localparam int OPC_LSB    = 48;
    localparam int LANE_LSB   = 41;
    localparam int MODE_BIT   = 40;
    localparam int MASK_LSB   = 20;
    localparam int SRC_LSB    = 8;
    localparam int DST_LSB    = 0;

    localparam logic [15:0] OPC_CARE     = 16'hFEF8;
    localparam logic [15:0] OPC_REG2PRED = 16'h38F0;
    localparam logic [15:0] OPC_PRED2REG = 16'h38E8;

    typedef enum logic {
        XFER_PRED = 1'b0,
        XFER_CC   = 1'b1
    } xfer_mode_e;

    typedef enum logic [1:0] {
        OPK_NONE     = 2'd0,
        OPK_REG2PRED = 2'd1,
        OPK_PRED2REG = 2'd2
    } op_kind_e;

    typedef struct packed {
        op_kind_e               kind;
        xfer_mode_e             mode;
        logic [NUM_PRED-1:0]    mask;
        logic [LANE_W-1:0]      lane;
        logic [IDX_W-1:0]       src;
        logic [IDX_W-1:0]       dst;
    } xfer_dec_t;

    function automatic logic opc_hit(input logic [15:0] opc, input logic [15:0] pat);
        return (opc & OPC_CARE) == pat;
    endfunction

endpackage

// File: rtl/pxu_decode.sv
module pxu_decode
    import pxu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output xfer_dec_t          dec
);
    logic [15:0] opc;

    always_comb begin
        opc      = instr[OPC_LSB +: 16];
        dec.mode = xfer_mode_e'(instr[MODE_BIT]);
        dec.mask = instr[MASK_LSB +: NUM_PRED];
        dec.lane = instr[LANE_LSB +: LANE_W];
        dec.src  = instr[SRC_LSB +: IDX_W];
        dec.dst  = instr[DST_LSB +: IDX_W];
        if (opc_hit(opc, OPC_REG2PRED))
            dec.kind = OPK_REG2PRED;
        else if (opc_hit(opc, OPC_PRED2REG))
            dec.kind = OPK_PRED2REG;
        else
            dec.kind = OPK_NONE;
    end
endmodule

// File: rtl/pxu_exec.sv
module pxu_exec
    import pxu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  xfer_dec_t           dec,
    input  logic [DATA_W-1:0]   src_data,
    input  logic [NUM_PRED-1:0] pred_in,
    output logic                unsup,
    output logic                rf_we,
    output logic [DATA_W-1:0]   rf_wdata,
    output logic [NUM_PRED-1:0] pred_we,
    output logic [NUM_PRED-1:0] pred_wdata
);
    localparam int NUM_LANES = DATA_W / BYTE_W;
    localparam logic [IDX_W-1:0] ZERO_IDX = '1;

    logic [DATA_W-1:0] src_eff;
    logic [BYTE_W-1:0] lane_byte;
    logic [BYTE_W-1:0] packed_byte;
    logic [DATA_W-1:0] spliced;
    logic              is_pred_mode;

    assign src_eff      = (dec.src == ZERO_IDX) ? '0 : src_data;
    assign lane_byte    = src_eff[dec.lane * BYTE_W +: BYTE_W];
    assign packed_byte  = {{(BYTE_W-NUM_PRED){1'b0}}, pred_in & dec.mask};
    assign is_pred_mode = (dec.mode == XFER_PRED);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign spliced[g*BYTE_W +: BYTE_W] =
            (dec.lane == LANE_W'(g)) ? packed_byte : src_eff[g*BYTE_W +: BYTE_W];
    end

    assign pred_wdata = lane_byte[NUM_PRED-1:0];
    assign rf_wdata   = spliced;

    always_comb begin
        unsup   = 1'b0;
        rf_we   = 1'b0;
        pred_we = '0;
        if (dec.kind == OPK_NONE || !is_pred_mode) begin
            unsup = 1'b1;
        end else if (dec.kind == OPK_REG2PRED) begin
            pred_we = dec.mask;
        end else begin
            rf_we = (dec.dst != ZERO_IDX);
        end
    end
endmodule

// File: rtl/pred_xfer_unit.sv
module pred_xfer_unit
    import pxu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [INSTR_W-1:0]  instr,
    output logic [IDX_W-1:0]    src_idx,
    input  logic [DATA_W-1:0]   src_data,
    input  logic [NUM_PRED-1:0] pred_in,
    input  logic                out_ready,
    output logic                out_valid,
    output logic                out_unsup,
    output logic                rf_we,
    output logic [IDX_W-1:0]    rf_waddr,
    output logic [DATA_W-1:0]   rf_wdata,
    output logic [NUM_PRED-1:0] pred_we,
    output logic [NUM_PRED-1:0] pred_wdata
);
    xfer_dec_t           dec;
    logic                x_unsup;
    logic                x_rf_we;
    logic [DATA_W-1:0]   x_rf_wdata;
    logic [NUM_PRED-1:0] x_pred_we;
    logic [NUM_PRED-1:0] x_pred_wdata;

    pxu_decode u_decode (
        .instr (instr),
        .dec   (dec)
    );

    pxu_exec #(.DATA_W(DATA_W)) u_exec (
        .dec        (dec),
        .src_data   (src_data),
        .pred_in    (pred_in),
        .unsup      (x_unsup),
        .rf_we      (x_rf_we),
        .rf_wdata   (x_rf_wdata),
        .pred_we    (x_pred_we),
        .pred_wdata (x_pred_wdata)
    );

    assign src_idx  = dec.src;
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_unsup  <= 1'b0;
            rf_we      <= 1'b0;
            rf_waddr   <= '0;
            rf_wdata   <= '0;
            pred_we    <= '0;
            pred_wdata <= '0;
        end else if (in_ready) begin
            out_valid  <= in_valid;
            out_unsup  <= in_valid && x_unsup;
            rf_we      <= in_valid && x_rf_we;
            pred_we    <= in_valid ? x_pred_we : '0;
            rf_waddr   <= dec.dst;
            rf_wdata   <= x_rf_wdata;
            pred_wdata <= x_pred_wdata;
        end
    end
endmodule

// File: rtl/pxu_checker.sv
module pxu_checker
    import pxu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                in_ready,
    input logic                out_ready,
    input logic                out_valid,
    input logic                out_unsup,
    input logic                rf_we,
    input logic [IDX_W-1:0]    rf_waddr,
    input logic [DATA_W-1:0]   rf_wdata,
    input logic [NUM_PRED-1:0] pred_we,
    input logic [NUM_PRED-1:0] pred_wdata
);
    a_r8_unsup_quiet: assert property (@(posedge clk) disable iff (rst)
        out_unsup |-> (!rf_we && pred_we == '0));

    a_r11_one_target: assert property (@(posedge clk) disable iff (rst)
        !(rf_we && (pred_we != '0)));

    a_r6_no_zero_write: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (rf_waddr != '1));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!rf_we && pred_we == '0 && !out_unsup));

    a_r9_accept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    a_r10_stall_blocks: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(rf_wdata) && $stable(rf_we)
            && $stable(pred_we) && $stable(pred_wdata) && $stable(out_unsup)
            && $stable(rf_waddr)));
endmodule

bind pred_xfer_unit pxu_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_unsup  (out_unsup),
    .rf_we      (rf_we),
    .rf_waddr   (rf_waddr),
    .rf_wdata   (rf_wdata),
    .pred_we    (pred_we),
    .pred_wdata (pred_wdata)
);

// File: tb/pred_xfer_unit_tb.sv
module pred_xfer_unit_tb;
    localparam int DW = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] instr = '0;
    logic [7:0]  src_idx;
    logic [31:0] src_data = '0;
    logic [6:0]  pred_in = '0;
    logic        out_ready = 1'b1;
    logic        out_valid, out_unsup, rf_we;
    logic [7:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic [6:0]  pred_we, pred_wdata;

    int checks = 0;
    int errors = 0;

    // expected state
    logic        e_valid = 0, e_unsup = 0, e_rfwe = 0, e_held = 0;
    logic [7:0]  e_waddr = 0;
    logic [31:0] e_wdata = 0;
    logic [6:0]  e_pwe = 0, e_pwd = 0;
    string       t_un = "R9", t_rf = "R9", t_pd = "R9", t_pwe = "R9";

    always #5 clk = ~clk;

    pred_xfer_unit #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .instr(instr), .src_idx(src_idx), .src_data(src_data), .pred_in(pred_in),
        .out_ready(out_ready), .out_valid(out_valid), .out_unsup(out_unsup),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .pred_we(pred_we), .pred_wdata(pred_wdata)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic string tg(string base);
        return e_held ? "R10" : base;
    endfunction

    function automatic logic [63:0] mk(logic [15:0] opc, logic [1:0] lane, logic mode,
                                       logic [6:0] mask, logic [7:0] s, logic [7:0] d);
        return {opc, 5'b0, lane, mode, 13'b0, mask, 4'b0, s, d};
    endfunction

    // behavioural reference: sets the e_* values for one accepted instruction
    task automatic model(logic [63:0] ins, logic [31:0] sd, logic [6:0] pr);
        logic [15:0] opc = ins[63:48];
        int lane = int'(ins[42:41]);
        int off  = lane * 8;
        logic [6:0] msk = ins[26:20];
        logic [7:0] s = ins[15:8];
        logic [7:0] d = ins[7:0];
        logic [31:0] sv = (s == 8'd255) ? 32'd0 : sd;
        bit isr = (opc[15:9] == 7'b0011100) && (opc[7:3] == 5'b11110);
        bit isp = (opc[15:9] == 7'b0011100) && (opc[7:3] == 5'b11101);
        logic [7:0] nb = 0;
        e_valid = 1; e_unsup = 0; e_rfwe = 0; e_pwe = 0; e_pwd = 0;
        e_waddr = d; e_wdata = 0;
        t_un = "R9"; t_rf = "R11"; t_pwe = "R11"; t_pd = "R1";
        if (!isr && !isp) begin
            e_unsup = 1; t_un = "R8"; t_rf = "R8"; t_pwe = "R8";
        end else if (ins[40]) begin
            e_unsup = 1; t_un = "R7"; t_rf = "R7"; t_pwe = "R7";
        end else if (isr) begin
            for (int i = 0; i < 7; i++)
                if (msk[i]) begin
                    e_pwe[i] = 1'b1;
                    e_pwd[i] = sv[off + i];
                end
            t_pwe = "R2";
            t_pd = (s == 8'd255) ? "R5" : (lane != 0) ? "R3" : "R1";
        end else begin
            for (int i = 0; i < 7; i++)
                if (pr[i] && msk[i]) nb[i] = 1'b1;
            e_wdata = sv;
            for (int b = 0; b < 8; b++) e_wdata[off + b] = nb[b];
            e_rfwe = (d != 8'd255);
            t_rf = (d == 8'd255) ? "R6" : (s == 8'd255) ? "R5" : (lane != 0) ? "R3" : "R4";
            t_un = (d == 8'd255) ? "R6" : "R9";
        end
    endtask

    task automatic step(logic v, logic [63:0] ins, logic [31:0] sd, logic [6:0] pr, logic ordy);
        logic exp_rdy;
        @(negedge clk);
        chk(tg("R9"), "out_valid", 32'(out_valid), 32'(e_valid));
        chk(tg(t_un), "out_unsup", 32'(out_unsup), 32'(e_unsup));
        chk(tg(t_rf), "rf_we", 32'(rf_we), 32'(e_rfwe));
        chk(tg(t_pwe), "pred_we", 32'(pred_we), 32'(e_pwe));
        if (e_valid && e_rfwe) begin
            chk(tg(t_rf), "rf_waddr", 32'(rf_waddr), 32'(e_waddr));
            chk(tg(t_rf), "rf_wdata", rf_wdata, e_wdata);
        end
        if (e_valid && e_pwe != 0)
            chk(tg(t_pd), "pred_wdata", 32'(pred_wdata & e_pwe), 32'(e_pwd));
        in_valid = v; instr = ins; src_data = sd; pred_in = pr; out_ready = ordy;
        #1;
        exp_rdy = !e_valid || ordy;
        chk("R10", "in_ready", 32'(in_ready), 32'(exp_rdy));
        chk("R4", "src_idx", 32'(src_idx), 32'(ins[15:8]));
        if (exp_rdy) begin
            e_held = 0;
            if (v) model(ins, sd, pr);
            else begin
                e_valid = 0; e_unsup = 0; e_rfwe = 0; e_pwe = 0;
                t_un = "R9"; t_rf = "R9"; t_pwe = "R9"; t_pd = "R9";
            end
        end else begin
            e_held = 1;
        end
    endtask

    localparam logic [15:0] RP = 16'h38F0;
    localparam logic [15:0] PR = 16'h38E8;

    initial begin : watchdog
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9", "reset out_valid", 32'(out_valid), 0);
        chk("R9", "reset rf_we", 32'(rf_we), 0);
        chk("R9", "reset pred_we", 32'(pred_we), 0);
        chk("R9", "reset out_unsup", 32'(out_unsup), 0);
        rst = 1'b0;

        // register-to-predicate, all lanes, full and partial masks
        for (int l = 0; l < 4; l++) begin
            step(1, mk(RP, 2'(l), 0, 7'h7F, 8'd3, 8'd9), 32'hA5C3_5A3C, 7'h00, 1);
            step(1, mk(RP, 2'(l), 0, 7'h15, 8'd3, 8'd9), 32'hFFFF_FFFF, 7'h7F, 1);
        end
        // don't-care opcode bits set
        step(1, mk(RP | 16'h0107, 2'd1, 0, 7'h6A, 8'd4, 8'd1), 32'h1234_5678, 7'h00, 1);
        step(1, mk(PR | 16'h0107, 2'd2, 0, 7'h7F, 8'd4, 8'd1), 32'h1234_5678, 7'h55, 1);
        // predicate-to-register, all lanes
        for (int l = 0; l < 4; l++)
            step(1, mk(PR, 2'(l), 0, 7'h3C, 8'd7, 8'd12), 32'hFFFF_FFFF, 7'h7F, 1);
        step(1, mk(PR, 2'd3, 0, 7'h00, 8'd7, 8'd12), 32'hDEAD_BEEF, 7'h7F, 1);
        // index 255 source and destination
        step(1, mk(RP, 2'd0, 0, 7'h7F, 8'd255, 8'd0), 32'hFFFF_FFFF, 7'h00, 1);
        step(1, mk(PR, 2'd1, 0, 7'h7F, 8'd255, 8'd5), 32'hFFFF_FFFF, 7'h2B, 1);
        step(1, mk(PR, 2'd1, 0, 7'h7F, 8'd5, 8'd255), 32'hFFFF_FFFF, 7'h2B, 1);
        // condition-code mode and foreign opcodes
        step(1, mk(RP, 2'd0, 1, 7'h7F, 8'd2, 8'd3), 32'hFFFF_FFFF, 7'h00, 1);
        step(1, mk(PR, 2'd0, 1, 7'h7F, 8'd2, 8'd3), 32'hFFFF_FFFF, 7'h7F, 1);
        step(1, mk(16'h38F8, 2'd0, 0, 7'h7F, 8'd2, 8'd3), 32'hFFFF_FFFF, 7'h7F, 1);
        step(1, mk(16'h0000, 2'd0, 0, 7'h7F, 8'd2, 8'd3), 32'hFFFF_FFFF, 7'h7F, 1);
        // backpressure
        step(1, mk(PR, 2'd2, 0, 7'h7F, 8'd1, 8'd2), 32'h0F0F_0F0F, 7'h41, 1);
        step(1, mk(RP, 2'd0, 0, 7'h7F, 8'd1, 8'd2), 32'h0000_0000, 7'h00, 0);
        step(1, mk(RP, 2'd0, 0, 7'h7F, 8'd1, 8'd2), 32'h0000_0000, 7'h00, 0);
        step(0, 64'd0, 32'd0, 7'h00, 1);
        step(0, 64'd0, 32'd0, 7'h00, 1);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            logic [63:0] ins;
            int k = int'($urandom_range(0, 9));
            logic [15:0] opc = (k < 4) ? RP : (k < 8) ? PR : 16'($urandom);
            logic [7:0] s = ($urandom_range(0, 7) == 0) ? 8'd255 : 8'($urandom);
            logic [7:0] d = ($urandom_range(0, 7) == 0) ? 8'd255 : 8'($urandom);
            ins = mk(opc | (16'h0107 & 16'($urandom)), 2'($urandom),
                     ($urandom_range(0, 9) == 0), 7'($urandom), s, d);
            ins[47:43] = 5'($urandom);
            ins[39:27] = 13'($urandom);
            ins[19:16] = 4'($urandom);
            step(($urandom_range(0, 3) != 0), ins, $urandom, 7'($urandom),
                 ($urandom_range(0, 3) != 0));
        end
        step(0, 64'd0, 32'd0, 7'h00, 1);
        step(0, 64'd0, 32'd0, 7'h00, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule